// File: doc/BRIEF.md
# Fault Isolation Register Bank

This block collects hardware error events into a 64-bit fault register and tells the rest of the chip when an error needs attention. A 64-bit event input is ORed into the fault register on every clock. A mask register selects which fault bits are ignored. The attention output is high while any fault bit is set and not masked. A first-error register keeps the unmasked fault vector from the cycle in which the unmasked set went from empty to non-empty, so software can see which error came first.

Software reaches the bank over a simple register bus that carries only full 64-bit accesses. The fault register and the mask register each have three write addresses: one replaces the register, one clears bits by AND, and one sets bits by OR. Two plain action registers hold the response policy. Writing the first-error register clears it. Two report addresses take writes and ignore them. A write to any address outside the map raises an error pulse and changes no register.

Top module: `fir_bank`

## Requirements
- R1: The register index is the byte address shifted right by three, so address bits [2:0] do not affect decode. Index map: 0 fault replace, 1 fault AND, 2 fault OR, 3 mask replace, 4 mask AND, 5 mask OR, 6 action 0, 7 action 1, 8 first-error, 9 and 10 report (no effect).
- R2: A write to index 0 replaces the whole fault register with the write data.
- R3: A write to index 1 sets fault to fault AND data, so zero data bits clear the matching fault bits.
- R4: A write to index 2 sets fault to fault OR data.
- R5: Indices 3, 4 and 5 apply replace, AND and OR to the mask register in the same way.
- R6: The two action registers at indices 6 and 7 are plain read/write 64-bit registers.
- R7: Any write to index 8 sets the first-error register to zero, whatever the write data.
- R8: Writes to indices 9 and 10 are accepted without error, change no register, and those indices read as zero.
- R9: A write to an index of 11 or more pulses err_o high in the following cycle and changes no register; a read of such an index returns zero and raises no error.
- R10: event_i is ORed into the fault register on every clock, after any bus write to the fault register in the same cycle has been applied.
- R11: attn_o is high exactly while (fault AND NOT mask) is nonzero, as held in the registers.
- R12: When the unmasked fault vector goes from zero to nonzero, the first-error register takes the new unmasked vector; a capture wins over a first-error clear in the same cycle, and it holds its value otherwise.
- R13: Reset clears every register, rdata_o, err_o and attn_o to zero.
- R14: Read data appears on rdata_o in the cycle after the read request, and each alias index reads its target register (indices 1 and 2 read fault, 4 and 5 read mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | DATA_W | Write data |
| event_i | input | DATA_W | Hardware error events, ORed into the fault register |
| rdata_o | output | DATA_W | Registered read data |
| err_o | output | 1 | Registered pulse for a write to an unmapped index |
| attn_o | output | 1 | High while any unmasked fault bit is set |

## Verification
Every result is due one clock after its cause. A bus write or an event changes the registers at the next edge, so attn_o and any later read show it from then on. Read data and the unmapped-write error are registered and appear one edge after the request. The bench keeps a behavioural model that advances on the same edge and compares rdata_o, err_o and attn_o half a cycle later, so each output is sampled in the cycle it is due. Directed reads check the stored register contents one cycle after the read is issued.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int unsigned IDX_FAULT     = 0;
  localparam int unsigned IDX_FAULT_AND = 1;
  localparam int unsigned IDX_FAULT_OR  = 2;
  localparam int unsigned IDX_MASK      = 3;
  localparam int unsigned IDX_MASK_AND  = 4;
  localparam int unsigned IDX_MASK_OR   = 5;
  localparam int unsigned IDX_ACT0      = 6;
  localparam int unsigned IDX_ACT1      = 7;
  localparam int unsigned IDX_FIRST     = 8;
  localparam int unsigned IDX_REPORT0   = 9;
  localparam int unsigned IDX_REPORT1   = 10;
  localparam int unsigned NUM_ACT       = 2;

  typedef struct packed {
    logic fault_wr;
    logic fault_and;
    logic fault_or;
    logic mask_wr;
    logic mask_and;
    logic mask_or;
    logic [NUM_ACT-1:0] act_wr;
    logic first_clr;
    logic unmapped;
  } fir_wr_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_FAULT,
    RD_MASK,
    RD_ACT0,
    RD_ACT1,
    RD_FIRST
  } fir_rd_e;
endpackage

// File: rtl/fir_decode.sv
module fir_decode
  import fir_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output fir_wr_t           wr_o,
  output fir_rd_e           rd_sel_o
);
  localparam int unsigned IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             wr_en;

  assign idx   = addr_i[ADDR_W-1:3];
  assign wr_en = req_i & we_i;

  always_comb begin
    wr_o     = '0;
    rd_sel_o = RD_ZERO;
    case (idx)
      IDX_W'(IDX_FAULT):     begin wr_o.fault_wr  = wr_en; rd_sel_o = RD_FAULT; end
      IDX_W'(IDX_FAULT_AND): begin wr_o.fault_and = wr_en; rd_sel_o = RD_FAULT; end
      IDX_W'(IDX_FAULT_OR):  begin wr_o.fault_or  = wr_en; rd_sel_o = RD_FAULT; end
      IDX_W'(IDX_MASK):      begin wr_o.mask_wr   = wr_en; rd_sel_o = RD_MASK;  end
      IDX_W'(IDX_MASK_AND):  begin wr_o.mask_and  = wr_en; rd_sel_o = RD_MASK;  end
      IDX_W'(IDX_MASK_OR):   begin wr_o.mask_or   = wr_en; rd_sel_o = RD_MASK;  end
      IDX_W'(IDX_ACT0):      begin wr_o.act_wr[0] = wr_en; rd_sel_o = RD_ACT0;  end
      IDX_W'(IDX_ACT1):      begin wr_o.act_wr[1] = wr_en; rd_sel_o = RD_ACT1;  end
      IDX_W'(IDX_FIRST):     begin wr_o.first_clr = wr_en; rd_sel_o = RD_FIRST; end
      IDX_W'(IDX_REPORT0),
      IDX_W'(IDX_REPORT1):   rd_sel_o = RD_ZERO;
      default:               wr_o.unmapped = wr_en;
    endcase
  end
endmodule

// File: rtl/fir_alias_reg.sv
module fir_alias_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         and_i,
  input  logic         or_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] d_o,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] base;

  always_comb begin
    base = q;
    if (wr_i)       base = wdata_i;
    else if (and_i) base = q & wdata_i;
    else if (or_i)  base = q | wdata_i;
  end

  // hardware set bits land after the bus update
  assign d_o = base | set_i;
  assign q_o = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d_o;
  end

  // R3 (and R5 for the mask instance)
  assert_and_alias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (and_i && !wr_i && !or_i) |=> q_o == (($past(q_o) & $past(wdata_i)) | $past(set_i)));

  // R4 (and R5 for the mask instance)
  assert_or_alias_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (or_i && !wr_i && !and_i) |=> q_o == ($past(q_o) | $past(wdata_i) | $past(set_i)));

  assert_set_sticks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (q_o & $past(set_i)) == $past(set_i));
endmodule

// File: rtl/fir_first.sv
module fir_first #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] unm_q_i,
  input  logic [W-1:0] unm_d_i,
  output logic [W-1:0] q_o
);
  logic capture;

  assign capture = (unm_q_i == '0) && (unm_d_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (capture) q_o <= unm_d_i;
    else if (clr_i)   q_o <= '0;
  end

  assert_clear_any_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (unm_q_i != '0 || unm_d_i == '0)) |=> q_o == '0);

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (unm_q_i != '0 || unm_d_i == '0)) |=> $stable(q_o));
endmodule

// File: rtl/fir_bank.sv
module fir_bank
  import fir_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] event_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              attn_o
);
  fir_wr_t     wr;
  fir_rd_e     rd_sel;
  logic [DATA_W-1:0] fault_d, fault_q, mask_d, mask_q, first_q;
  logic [DATA_W-1:0] act_q [NUM_ACT];
  logic [DATA_W-1:0] unm_q, unm_d, rd_mux;

  fir_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wr_o     (wr),
    .rd_sel_o (rd_sel)
  );

  fir_alias_reg #(.W(DATA_W)) u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr.fault_wr),
    .and_i   (wr.fault_and),
    .or_i    (wr.fault_or),
    .wdata_i (wdata_i),
    .set_i   (event_i),
    .d_o     (fault_d),
    .q_o     (fault_q)
  );

  fir_alias_reg #(.W(DATA_W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr.mask_wr),
    .and_i   (wr.mask_and),
    .or_i    (wr.mask_or),
    .wdata_i (wdata_i),
    .set_i   ('0),
    .d_o     (mask_d),
    .q_o     (mask_q)
  );

  generate
    for (genvar a = 0; a < NUM_ACT; a++) begin : g_act
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          act_q[a] <= '0;
        else if (wr.act_wr[a]) act_q[a] <= wdata_i;
      end
    end
  endgenerate

  assign unm_q = fault_q & ~mask_q;
  assign unm_d = fault_d & ~mask_d;

  fir_first #(.W(DATA_W)) u_first (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wr.first_clr),
    .unm_q_i (unm_q),
    .unm_d_i (unm_d),
    .q_o     (first_q)
  );

  always_comb begin
    case (rd_sel)
      RD_FAULT: rd_mux = fault_q;
      RD_MASK:  rd_mux = mask_q;
      RD_ACT0:  rd_mux = act_q[0];
      RD_ACT1:  rd_mux = act_q[1];
      RD_FIRST: rd_mux = first_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= (req_i && !we_i) ? rd_mux : '0;
      err_o   <= wr.unmapped;
    end
  end

  assign attn_o = |unm_q;

  assert_err_only_on_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && we_i));

  assert_unmapped_no_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr.unmapped && event_i == '0) |=> ($stable(fault_q) && $stable(mask_q) && $stable(first_q)));

  assert_first_on_attn_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(attn_o) |-> (first_q == (fault_q & ~mask_q)));

  assert_attn_needs_fault_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_o |-> (fault_q != '0 && mask_q != '1));
endmodule

// File: tb/fir_bank_tb_top.sv
`timescale 1ns/1ps
module fir_bank_tb_top;
  localparam int DW = 64;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] ev = '0;
  logic [DW-1:0] rdata;
  logic          err;
  logic          attn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [DW-1:0] m_fault = '0, m_mask = '0, m_a0 = '0, m_a1 = '0, m_first = '0;
  logic [DW-1:0] m_rdata = '0;
  logic          m_err = 1'b0;

  always #2.5 clk = ~clk;

  fir_bank #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .event_i (ev),
    .rdata_o (rdata),
    .err_o   (err),
    .attn_o  (attn)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fault = '0; m_mask = '0; m_a0 = '0; m_a1 = '0; m_first = '0;
      m_rdata = '0; m_err = 1'b0;
    end else begin
      int idx;
      logic [DW-1:0] nf, nm, nfirst, old_u, new_u;
      idx = int'(addr) / 8;
      m_rdata = '0;
      if (req && !we) begin
        if (idx <= 2) m_rdata = m_fault;
        else if (idx <= 5) m_rdata = m_mask;
        else if (idx == 6) m_rdata = m_a0;
        else if (idx == 7) m_rdata = m_a1;
        else if (idx == 8) m_rdata = m_first;
      end
      m_err = req && we && (idx > 10);
      nf = m_fault; nm = m_mask; nfirst = m_first;
      if (req && we) begin
        if (idx == 0) nf = wdata;
        if (idx == 1) nf = m_fault & wdata;
        if (idx == 2) nf = m_fault | wdata;
        if (idx == 3) nm = wdata;
        if (idx == 4) nm = m_mask & wdata;
        if (idx == 5) nm = m_mask | wdata;
        if (idx == 6) m_a0 = wdata;
        if (idx == 7) m_a1 = wdata;
        if (idx == 8) nfirst = '0;
      end
      nf = nf | ev;
      old_u = m_fault & ~m_mask;
      new_u = nf & ~nm;
      if (old_u == '0 && new_u != '0) nfirst = new_u;
      m_fault = nf; m_mask = nm; m_first = nfirst;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R14 rdata vs model", rdata, m_rdata);
      chk("R9 err vs model", DW'(err), DW'(m_err));
      chk("R11 attn vs model", DW'(attn), DW'(|(m_fault & ~m_mask)));
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [DW-1:0] e = '0);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; ev = e;
    @(negedge clk);
    req = 1'b0; we = 1'b0; ev = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 rdata after reset", rdata, '0);
    chk("R13 attn after reset", DW'(attn), '0);
    chk("R13 err after reset", DW'(err), '0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00, '0, "R13 fault cleared");
    rd(8'h40, '0, "R13 first cleared");

    wr(8'h00, 64'h00FF);
    rd(8'h00, 64'h00FF, "R2 replace fault");
    chk("R11 attn high with unmasked fault", DW'(attn), 64'd1);
    rd(8'h40, 64'h00FF, "R12 first capture");
    wr(8'h08, 64'h00F0);
    rd(8'h00, 64'h00F0, "R3 and-clear fault");
    wr(8'h10, 64'h1000);
    rd(8'h00, 64'h10F0, "R4 or-set fault");
    rd(8'h05, 64'h10F0, "R1 low address bits ignored");
    rd(8'h08, 64'h10F0, "R14 and alias reads fault");
    rd(8'h10, 64'h10F0, "R14 or alias reads fault");

    wr(8'h18, '1);
    chk("R11 attn low when fully masked", DW'(attn), '0);
    wr(8'h20, ~64'h1000);
    chk("R11 attn high after unmask", DW'(attn), 64'd1);
    rd(8'h40, 64'h1000, "R12 capture on zero to nonzero");
    rd(8'h18, ~64'h1000, "R5 and-clear mask");
    wr(8'h28, 64'h1000);
    rd(8'h20, '1, "R5 or-set mask");

    wr(8'h40, '1);
    rd(8'h40, '0, "R7 first cleared by write of ones");

    wr(8'h30, 64'hA5A5_5A5A_0F0F_F0F0);
    wr(8'h38, 64'h0123_4567_89AB_CDEF);
    rd(8'h30, 64'hA5A5_5A5A_0F0F_F0F0, "R6 action0");
    rd(8'h38, 64'h0123_4567_89AB_CDEF, "R6 action1");

    wr(8'h48, '1);
    chk("R8 no error on report write", DW'(err), '0);
    wr(8'h50, '1);
    chk("R8 no error on status write", DW'(err), '0);
    rd(8'h48, '0, "R8 report reads zero");
    rd(8'h00, 64'h10F0, "R8 fault unchanged");

    wr(8'hA0, 64'hDEAD);
    chk("R9 error pulse on unmapped write", DW'(err), 64'd1);
    @(negedge clk);
    chk("R9 error pulse ends", DW'(err), '0);
    rd(8'h00, 64'h10F0, "R9 fault unchanged");
    rd(8'h18, '1, "R9 mask unchanged");
    rd(8'h30, 64'hA5A5_5A5A_0F0F_F0F0, "R9 action unchanged");
    rd(8'hA0, '0, "R9 unmapped read zero");
    chk("R9 no error on unmapped read", DW'(err), '0);

    wr(8'h00, 64'h0001, 64'h0100);
    rd(8'h00, 64'h0101, "R10 event after replace");
    wr(8'h08, 64'h0000, 64'h0040);
    rd(8'h00, 64'h0040, "R10 event after and-clear");
    ev = 64'h8000;
    @(negedge clk);
    ev = '0;
    rd(8'h00, 64'h8040, "R10 event alone");

    wr(8'h18, '0);
    wr(8'h00, '0);
    chk("R11 attn low with no faults", DW'(attn), '0);
    wr(8'h40, '1, 64'h0004);
    rd(8'h40, 64'h0004, "R12 capture beats clear");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule